// File: doc/BRIEF.md
# Configurable GPIO Bank with Per-Pin Drive Mode

This block is one bank of up to eight general-purpose pins, reached through four byte registers on an internal configuration bus. Software picks, per pin, whether the pin drives or listens, what level it drives, and whether it drives actively in both directions (push-pull) or only pulls low and lets an external resistor pull high (open-drain). The level on the pads is passed through a two-stage synchroniser before it can be read.

The bank is placed on the bus by a base-offset parameter. Its four registers sit at base+0 (direction), base+1 (output data), base+2 (pin status) and base+3 (drive mode), so banks may be packed four bytes apart or spread sixteen bytes apart. A second parameter sets how many pins exist. A third selects a build variant in which a direction bit of 1 means input, and the register at base+1 both drives the pins and reports their level, leaving base+2 unused.

Writes take effect on the rising clock edge where `cfg_wr` is high. Reads are combinational from `cfg_addr` and return 0 for any address outside the bank.

Top module: `gpio_bank`

## Requirements
- R1: After reset, no pad is driven (`pad_oe` all 0), output data reads 0, drive mode reads 0, and direction reads 0x00 in the normal variant or the implemented-pin mask in the inverted variant.
- R2: Only offsets base+0, base+1, base+2 and base+3 (modulo 256) belong to the bank; any other address reads 0 and a write to it changes nothing, and a write to base+2 changes nothing.
- R3: In the normal variant a pin is an output when its direction bit is 1; an input pin never has its `pad_oe` bit set.
- R4: In the inverted variant a pin is an output when its direction bit is 0; a direction bit of 1 keeps `pad_oe` clear.
- R5: A drive-mode bit of 0 selects open-drain: `pad_out` is 0, and an output pin asserts `pad_oe` only while its data bit is 0.
- R6: A drive-mode bit of 1 selects push-pull: an output pin asserts `pad_oe` and `pad_out` equals its data bit.
- R7: In the normal variant base+2 returns the pad levels sampled by two flops: a pad change made before rising edge N is still hidden after edge N and visible after edge N+1.
- R8: In the inverted variant base+1 reads back, per pin, the data latch for output pins and the synchronised pad level for input pins; base+2 reads 0.
- R9: Register bits above the pin count read 0 and discard written ones; the pad ports are only as wide as the pin count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration bus |
| cfg_addr | input | 8 | Byte address on the configuration bus |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data, 0 outside the bank |
| pad_in | input | PIN_COUNT | Levels seen on the pads |
| pad_oe | output | PIN_COUNT | Pad output enable per pin |
| pad_out | output | PIN_COUNT | Pad output level per pin |

## Verification
The hardest state to reach from the ports is the merged readback of the inverted variant, where one byte mixes latched data and synchronised pad levels according to direction; the bench sweeps all 256 direction patterns with data, mode and pad levels derived from the loop index, holding pads steady long enough for the synchroniser to settle. The two-edge synchroniser latency is pinned by changing pads at a falling edge and reading status after one and after two rising edges. Two instances share one bus at adjacent four-byte bases, so every write also checks that the neighbour ignores it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        OFS_DIR  = 2'd0,
        OFS_DATA = 2'd1,
        OFS_STAT = 2'd2,
        OFS_MODE = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] dout;
        logic [REG_W-1:0] mode;
    } bank_regs_t;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad,
    output logic [NPINS-1:0] stat
);

    typedef struct packed {
        logic [NPINS-1:0] meta;
        logic [NPINS-1:0] held;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = pad;
        sync_d.held = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign stat = sync_q.held;

endmodule

// File: rtl/gpio_bank_drive.sv
module gpio_bank_drive #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] is_out,
    input  logic [NPINS-1:0] dout,
    input  logic [NPINS-1:0] mode,
    output logic [NPINS-1:0] oe,
    output logic [NPINS-1:0] lvl
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // push-pull drives both levels; open-drain only pulls low
        assign oe[i]  = is_out[i] & (mode[i] | ~dout[i]);
        assign lvl[i] = mode[i] & dout[i];
    end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter logic [7:0] BASE   = 8'hF0,
    parameter int         NPINS  = 8,
    parameter bit         MERGED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    input  logic [NPINS-1:0] stat,
    output logic [7:0]       cfg_rdata,
    output bank_regs_t       regs_q,
    output logic [7:0]       is_out
);

    localparam logic [7:0] PIN_MASK = 8'((9'd1 << NPINS) - 9'd1);
    localparam logic [7:0] DIR_RST  = MERGED ? PIN_MASK : 8'h00;

    bank_regs_t regs_d;
    logic [7:0] ofs;
    logic       hit;
    reg_ofs_e   sel;
    logic [7:0] stat_ext;
    logic [7:0] data_view;

    always_comb begin
        ofs = cfg_addr - BASE;
        hit = (ofs < 8'd4);
        sel = reg_ofs_e'(ofs[1:0]);
    end

    always_comb begin
        stat_ext             = '0;
        stat_ext[NPINS-1:0]  = stat;
    end

    always_comb begin
        regs_d = regs_q;
        if (cfg_wr && hit) begin
            case (sel)
                OFS_DIR:  regs_d.dir  = cfg_wdata & PIN_MASK;
                OFS_DATA: regs_d.dout = cfg_wdata & PIN_MASK;
                OFS_MODE: regs_d.mode = cfg_wdata & PIN_MASK;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{dir: DIR_RST, dout: 8'h00, mode: 8'h00};
        end else begin
            regs_q <= regs_d;
        end
    end

    if (MERGED) begin : g_merged
        assign is_out    = ~regs_q.dir & PIN_MASK;
        assign data_view = (regs_q.dout & is_out) | (stat_ext & ~is_out & PIN_MASK);
    end else begin : g_split
        assign is_out    = regs_q.dir;
        assign data_view = regs_q.dout;
    end

    always_comb begin
        cfg_rdata = '0;
        if (hit) begin
            case (sel)
                OFS_DIR:  cfg_rdata = regs_q.dir;
                OFS_DATA: cfg_rdata = data_view;
                OFS_STAT: cfg_rdata = MERGED ? 8'h00 : (stat_ext & PIN_MASK);
                OFS_MODE: cfg_rdata = regs_q.mode;
                default:  cfg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter logic [7:0] BANK_BASE      = 8'hF0,
    parameter int         PIN_COUNT      = 8,
    parameter bit         MERGED_VARIANT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [7:0]           cfg_addr,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [PIN_COUNT-1:0] pad_out
);

    logic [PIN_COUNT-1:0] stat_w;
    bank_regs_t           regs_w;
    logic [7:0]           is_out_w;

    gpio_bank_sync #(.NPINS(PIN_COUNT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pad   (pad_in),
        .stat  (stat_w)
    );

    gpio_bank_regs #(
        .BASE   (BANK_BASE),
        .NPINS  (PIN_COUNT),
        .MERGED (MERGED_VARIANT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .stat      (stat_w),
        .cfg_rdata (cfg_rdata),
        .regs_q    (regs_w),
        .is_out    (is_out_w)
    );

    gpio_bank_drive #(.NPINS(PIN_COUNT)) u_drive (
        .is_out (is_out_w[PIN_COUNT-1:0]),
        .dout   (regs_w.dout[PIN_COUNT-1:0]),
        .mode   (regs_w.mode[PIN_COUNT-1:0]),
        .oe     (pad_oe),
        .lvl    (pad_out)
    );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter logic [7:0] BASE   = 8'hF0,
    parameter int         NPINS  = 8,
    parameter bit         MERGED = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [7:0]       cfg_addr,
    input logic [7:0]       cfg_rdata,
    input logic [NPINS-1:0] pad_in,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_out,
    input bank_regs_t       regs
);

    localparam logic [7:0] PIN_MASK = 8'((9'd1 << NPINS) - 9'd1);

    logic [1:0]       age;
    logic [7:0]       ofs;
    logic [NPINS-1:0] want_out;
    logic [NPINS-1:0] mode_n;
    logic [NPINS-1:0] dout_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    always_comb begin
        ofs      = cfg_addr - BASE;
        mode_n   = regs.mode[NPINS-1:0];
        dout_n   = regs.dout[NPINS-1:0];
        want_out = MERGED ? ~regs.dir[NPINS-1:0] : regs.dir[NPINS-1:0];
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0));

    // R3
    input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~want_out) == '0);

    // R5
    od_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~mode_n) == '0) && ((pad_oe & ~mode_n & dout_n) == '0));

    // R6
    pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((want_out & mode_n & ~pad_oe) == '0) && ((pad_out ^ dout_n) & mode_n) == '0);

    // R7
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!MERGED && age == 2'd2 && ofs == 8'd2) |-> (cfg_rdata == (8'($past(pad_in, 2)) & PIN_MASK)));

    // R2
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (ofs > 8'd3 || ofs == 8'd2)) |=> $stable(regs));

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs.dir | regs.dout | regs.mode) & ~PIN_MASK) == 8'h00);

endmodule

bind gpio_bank gpio_bank_chk #(
    .BASE   (BANK_BASE),
    .NPINS  (PIN_COUNT),
    .MERGED (MERGED_VARIANT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .regs      (regs_w)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] rd_n, rd_i;
    logic [5:0] pad_n = 6'h00;
    logic [5:0] oe_n, out_n;
    logic [7:0] pad_i = 8'h00;
    logic [7:0] oe_i, out_i;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // normal variant, six pins, base 0xE0
    gpio_bank #(.BANK_BASE(8'hE0), .PIN_COUNT(6), .MERGED_VARIANT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd_n), .pad_in(pad_n),
        .pad_oe(oe_n), .pad_out(out_n)
    );

    // inverted/merged variant, eight pins, base 0xE4
    gpio_bank #(.BANK_BASE(8'hE4), .PIN_COUNT(8), .MERGED_VARIANT(1'b1)) uut_inv (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd_i), .pad_in(pad_i),
        .pad_oe(oe_i), .pad_out(out_i)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic setaddr(input logic [7:0] a);
        cfg_addr = a;
        #1;
    endtask

    task automatic wait_clk(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);

        // R1 reset state
        check("R1 normal oe", {2'b00, oe_n}, 8'h00);
        check("R1 inverted oe", oe_i, 8'h00);
        setaddr(8'hE0); check("R1 normal dir", rd_n, 8'h00);
        setaddr(8'hE1); check("R1 normal data", rd_n, 8'h00);
        setaddr(8'hE3); check("R1 normal mode", rd_n, 8'h00);
        setaddr(8'hE4); check("R1 inverted dir", rd_i, 8'hFF);
        setaddr(8'hE7); check("R1 inverted mode", rd_i, 8'h00);

        // R9 upper bits of a six-pin bank
        wr(8'hE0, 8'hFF);
        setaddr(8'hE0); check("R9 dir mask", rd_n, 8'h3F);
        wr(8'hE3, 8'hC0);
        setaddr(8'hE3); check("R9 mode mask", rd_n, 8'h00);

        // R2 foreign address and status writes are ignored
        wr(8'h10, 8'h00);
        setaddr(8'hE0); check("R2 foreign write", rd_n, 8'h3F);
        setaddr(8'h10); check("R2 foreign read", rd_n, 8'h00);
        setaddr(8'hE4); check("R2 neighbour read", rd_n, 8'h00);
        pad_n = 6'h15;
        wait_clk(3);
        wr(8'hE2, 8'h2A);
        setaddr(8'hE2); check("R2 status write", rd_n, 8'h15);
        setaddr(8'hE4); check("R2 neighbour dir untouched", rd_i, 8'hFF);

        // R7 two-flop latency
        @(negedge clk);
        pad_n = 6'h2A;
        setaddr(8'hE2); check("R7 before edge", rd_n, 8'h15);
        @(negedge clk);
        check("R7 after one edge", rd_n, 8'h15);
        @(negedge clk);
        check("R7 after two edges", rd_n, 8'h2A);

        // R3 R5 R6 normal variant sweep
        for (int v = 0; v < 64; v++) begin
            logic [7:0] d, m, x, eo, ev;
            x  = 8'(v);
            d  = 8'((v * 5) ^ 8'hC3);
            m  = 8'((v * 11) ^ 8'h5A);
            wr(8'hE0, x);
            wr(8'hE1, d);
            wr(8'hE3, m);
            eo = x & (m | ~d) & 8'h3F;
            ev = m & d & 8'h3F;
            check("R3 R5 R6 normal oe", {2'b00, oe_n}, eo);
            check("R5 R6 normal out", {2'b00, out_n}, ev);
            setaddr(8'hE1); check("R9 normal data", rd_n, d & 8'h3F);
            setaddr(8'hE3); check("R9 normal mode", rd_n, m & 8'h3F);
        end

        // R4 R5 R6 R8 inverted variant sweep
        for (int v = 0; v < 256; v++) begin
            logic [7:0] d, m, x, p, eo, ev, er;
            x  = 8'(v);
            d  = 8'((v * 7) ^ 8'h96);
            m  = 8'((v * 13) ^ 8'h3C);
            p  = 8'((v * 3) ^ 8'hA5);
            pad_i = p;
            wr(8'hE4, x);
            wr(8'hE5, d);
            wr(8'hE7, m);
            eo = ~x & (m | ~d);
            ev = m & d;
            er = (d & ~x) | (p & x);
            check("R4 R5 R6 inverted oe", oe_i, eo);
            check("R5 R6 inverted out", out_i, ev);
            setaddr(8'hE5); check("R8 merged readback", rd_i, er);
        end

        // R8 base+2 is unused in the inverted variant
        wr(8'hE6, 8'h77);
        setaddr(8'hE6); check("R8 unused status", rd_i, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule